// File: doc/BRIEF.md
# Serial Header-Framed Word Receiver

This block listens to a one-bit serial line that carries one bit per rising clock edge. The line rests at 0. While idle, the receiver looks for a run of four consecutive 1s. That run marks the start of a frame. The sixteen bits that follow are the payload, sent least significant bit first, and are taken as a two's complement word.

Once the last payload bit is in, the receiver shows the word on a parallel output and pulses a strobe for one cycle. A downstream consumer can then pick up the new value. The receiver goes back to searching at once. It is therefore ready well before the long quiet spell that the sender guarantees between frames.

Top module: `hdr_word_rx`

## Requirements
- R1: While synchronous reset is applied and in the first cycle after it, `word_valid` is 0 and `word_out` is all zeros. The receiver starts in the header-search state with its run-of-ones count cleared.
- R2: In the search state, four consecutive samples of `sdi` = 1 form the header. The very next sampled bit is payload bit 0.
- R3: In the search state, a 0 on `sdi` clears the count of ones. A run of one to three 1s followed by a 0 starts no frame.
- R4: The 16 payload bits fill `word_out` from bit 0 up to bit 15, in order of arrival.
- R5: `word_valid` is 1 for exactly one cycle. That cycle follows the clock edge that samples the 16th payload bit, and `word_out` holds the new word in that same cycle.
- R6: `word_out` changes only in a cycle where `word_valid` is 1, or through reset.
- R7: While a payload is being captured, header search is suspended. A payload containing runs of 1s, including 16'hFFFF, is received whole, and each frame gives exactly one strobe.
- R8: The sample right after the 16th payload bit is already examined by the header search with a fresh count. A frame that starts with no idle bit after the previous one is still received.
- R9: A reset applied partway through a payload drops the partial word: no strobe follows for it. The next well-formed frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data line, one bit per clock, rests at 0 |
| word_out | output | WORD_W | Last received payload word, held between strobes |
| word_valid | output | 1 | One-cycle pulse marking a new `word_out` |

## Verification
The hardest situation to create is a frame that starts on the cycle right after the previous payload ends, especially when that payload ends in 1s. A stale run count would then merge the payload's tail with the next header. The stimulus sends frames with random idle gaps that include zero. It also sends directed back-to-back frames of 16'hFFFF and of words ending in several 1s. Partial headers broken by a 0, a mid-payload reset and one full-length quiet gap cover the remaining paths.

// File: rtl/hdr_word_rx.sv
module hdr_word_rx #(
  parameter int WORD_W  = 16,
  parameter int HDR_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  localparam int CW = (WORD_W  > 1) ? $clog2(WORD_W)    : 1;
  localparam int RW = (HDR_LEN > 1) ? $clog2(HDR_LEN+1) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);
  localparam logic [RW-1:0] LAST_ONE = RW'(HDR_LEN - 1);

  typedef enum logic {S_SEARCH, S_CAPTURE} st_t;

  st_t               st;
  logic [RW-1:0]     run_cnt;
  logic [CW-1:0]     bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nxt;
  logic              in_capture;

  assign shreg_nxt  = {sdi, shreg[WORD_W-1:1]};
  assign in_capture = (st == S_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_SEARCH;
      run_cnt    <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (st)
        S_SEARCH: begin
          if (!sdi) begin
            run_cnt <= '0;
          end else if (run_cnt == LAST_ONE) begin
            run_cnt <= '0;
            bit_cnt <= '0;
            st      <= S_CAPTURE;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
        S_CAPTURE: begin
          shreg   <= shreg_nxt;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt    <= '0;
            word_out   <= shreg_nxt;
            word_valid <= 1'b1;
            st         <= S_SEARCH;
          end
        end
        default: st <= S_SEARCH;
      endcase
    end
  end

endmodule

// File: rtl/hdr_word_rx_chk.sv
module hdr_word_rx_chk #(
  parameter int WORD_W  = 16,
  parameter int HDR_LEN = 4,
  localparam int CW = (WORD_W  > 1) ? $clog2(WORD_W)    : 1,
  localparam int RW = (HDR_LEN > 1) ? $clog2(HDR_LEN+1) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              sdi,
  input logic              in_capture,
  input logic [RW-1:0]     run_cnt,
  input logic [CW-1:0]     bit_cnt,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!word_valid && !in_capture && run_cnt == '0 && word_out == '0));

  a_r2_header_enters_capture: assert property (@(posedge clk) disable iff (rst)
    (!in_capture && sdi && run_cnt == RW'(HDR_LEN - 1)) |=> in_capture);

  a_r3_zero_clears_run: assert property (@(posedge clk) disable iff (rst)
    (!in_capture && !sdi) |=> (run_cnt == '0));

  a_r5_strobe_after_last_bit: assert property (@(posedge clk) disable iff (rst)
    (in_capture && bit_cnt == CW'(WORD_W - 1)) |=> (word_valid && !in_capture));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(word_out)) |-> word_valid);

  a_r7_search_suspended: assert property (@(posedge clk) disable iff (rst)
    in_capture |-> (run_cnt == '0));

  a_r8_search_resumes: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !in_capture);

endmodule

bind hdr_word_rx hdr_word_rx_chk #(.WORD_W(WORD_W), .HDR_LEN(HDR_LEN)) chk (
  .clk        (clk),
  .rst        (rst),
  .sdi        (sdi),
  .in_capture (in_capture),
  .run_cnt    (run_cnt),
  .bit_cnt    (bit_cnt),
  .word_out   (word_out),
  .word_valid (word_valid)
);

// File: tb/hdr_word_rx_test.sv
module hdr_word_rx_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sdi = 1'b0;
  logic [W-1:0] word_out;
  logic         word_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_word [0:255];
  int           exp_cyc  [0:255];
  int           wr = 0;
  int           rd = 0;
  logic [W-1:0] last_word = '0;
  bit           prev_valid = 1'b0;

  hdr_word_rx #(.WORD_W(W), .HDR_LEN(4)) uut (
    .clk(clk), .rst(rst), .sdi(sdi), .word_out(word_out), .word_valid(word_valid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // Monitor: strobe timing and value (R4, R5, R7), holding (R6), no spurious strobe (R9)
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        last_word = '0;
      end else begin
        if (word_valid) begin
          if (rd < wr) begin
            check(cyc == exp_cyc[rd], "R5 strobe cycle", W'(cyc), W'(exp_cyc[rd]));
            check(word_out == exp_word[rd], "R4/R7 word value", word_out, exp_word[rd]);
            rd++;
          end else begin
            check(1'b0, "R9/R3 unexpected strobe", word_out, last_word);
          end
          check(!prev_valid, "R5 single-cycle strobe", W'(prev_valid), '0);
          last_word = word_out;
        end else begin
          if (rd < wr && cyc >= exp_cyc[rd]) begin
            check(1'b0, "R2/R8 missing strobe", '0, exp_word[rd]);
            rd++;
          end
          check(word_out == last_word, "R6 word held", word_out, last_word);
        end
      end
      prev_valid = word_valid;
    end
  end

  task automatic put_bit(input logic b);
    @(negedge clk);
    sdi = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b0);
  endtask

  task automatic send_frame(input logic [W-1:0] d);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    for (int i = 0; i < W; i++) put_bit(d[i]);
    exp_word[wr] = d;
    exp_cyc[wr]  = cyc + 1;
    wr++;
  endtask

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    check(word_valid == 1'b0, "R1 strobe low in reset", W'(word_valid), '0);
    check(word_out == '0, "R1 word cleared in reset", word_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check(word_valid == 1'b0 && word_out == '0, "R1 after reset", word_out, '0);

    idle(5);
    send_frame(16'h8001);                 // R2, R4 bit ordering
    idle(3);
    send_frame(16'h1234);
    idle(2);

    // R3: broken runs of ones start nothing
    put_bit(1'b1); put_bit(1'b0);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    idle(4);
    check(rd == wr, "R3 no frame from short runs", W'(rd), W'(wr));
    send_frame(16'h00F0);

    // R7, R8: payloads full of ones, frames back to back
    send_frame(16'hFFFF);
    send_frame(16'hFFFF);
    send_frame(16'hE00F);
    send_frame(16'h0003);                 // same stream as six leading ones
    idle(1);
    send_frame(16'h7FFF);
    send_frame(16'h8000);

    // R9: reset in mid payload
    idle(2);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    @(negedge clk);
    rst = 1'b1;
    sdi = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check(word_out == '0 && word_valid == 1'b0, "R9/R1 reset mid payload", word_out, '0);
    idle(30);
    check(rd == wr, "R9 no strobe for dropped word", W'(rd), W'(wr));
    send_frame(16'hA5C3);

    // Long guaranteed gap
    idle(6000);
    send_frame(16'h5A5A);

    // Random frames with random gaps, including zero
    for (int k = 0; k < 80; k++) begin
      send_frame(W'($urandom));
      idle($urandom_range(0, 25));
    end
    idle(5);
    check(rd == wr, "R7 one strobe per frame", W'(rd), W'(wr));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule